// File: doc/BRIEF.md
# Dual-User Protected Memory Bus Router

This block is the steering and control core of a flow-through error-correcting buffer. It sits between one protected memory bus and two 16-bit user buses. The memory bus carries a data word and a byte of check bits. Two select inputs set the transaction. The first chooses between a memory access and a direct transfer between the two users that leaves memory untouched. The second names which user is master. Each user has its own read/write strobe, an active-low output enable and an active-low memory-select. Only the master's read/write and memory-select strobes start a transaction. The other user takes part only as a listener, and only through its output enable.

On a memory write, the master's word goes onto the memory data bus and the generated check bits go onto the check bus. On a memory read, the master receives the stored word, raw or corrected. A diagnostic mode returns the syndrome and the stored check bits instead of the word. A single-error-correct, double-error-detect codec is instantiated inside the datapath. Every tri-state bus is modelled as a separate input, output and output-enable. All outputs are registered, so they show the inputs sampled at the previous rising clock edge.

Top module: `dual_user_bus_router`

## Requirements
- R1: While `rstN` is low, and after any rising edge with `rstN` low, every output enable is 0, every data output is 0 and both error flags are 1. Once reset is released, each output shows the inputs sampled at the previous rising edge.
- R2: Code definition. Data bit i is assigned a CHECK_W-bit column: the i-th smallest value that has exactly three bits set, counting in ascending order from i = 0. The check word is the XOR of the columns of all data bits that are 1. A memory write happens when `memSel`=1, the master's memory-select is 0 and the master's read/write is 0. During a write, `mdOut` is the master's input word, `mcOut` is its check word, `mdOe`=`mcOe`=1, and the master's own bus is not driven.
- R3: Listening. During a memory write, a memory read, or a transfer in which the master writes, the non-master bus is driven whenever its enable is 0. It carries the same word that is being moved: the written word, or the word returned to the master.
- R4: Memory read. A read happens when `memSel`=1, the master's memory-select is 0 and the master's read/write is 1. During a read, the master bus is driven when the master's enable is 0. With `syndReadN`=1 it carries the corrected word if `correctEn`=1, and the raw `mdIn` if `correctEn`=0.
- R5: Error flags during a read. The syndrome is the check word of `mdIn` XORed with `mcIn`. A syndrome equal to a data column makes `ceN`=0, and correction flips that data bit. A syndrome with exactly one bit set also makes `ceN`=0 but changes no data. Any other nonzero syndrome makes `ueN`=0. A zero syndrome leaves both flags at 1.
- R6: During a read with `syndReadN`=0, the returned word has the syndrome in bits 15:8 and `mcIn` in bits 7:0, regardless of `correctEn`.
- R7: With `memSel`=0, `mdOe`=`mcOe`=0. If the master's read/write is 0, the non-master bus takes the master's word. If the master's read/write is 1, the master bus takes the non-master's word when the master's enable is 0.
- R8: `masterSel`=0 makes user A master and `masterSel`=1 makes user B master. The non-master's read/write and memory-select have no effect. When the master's memory-select is 1, nothing is driven and both flags are 1.
- R9: A user bus whose enable is 1 is never driven. Any bus that is not driven outputs 0.
- R10: During writes, transfers and idle cycles both error flags are 1, and `correctEn` and `syndReadN` change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memSel | input | 1 | 1: memory access, 0: user-to-user transfer |
| masterSel | input | 1 | 0: user A master, 1: user B master |
| correctEn | input | 1 | 1: correct single data errors on read |
| syndReadN | input | 1 | Active-low syndrome/check-bit readback |
| rdA | input | 1 | User A read (1) / write (0) |
| enAN | input | 1 | User A output enable, active low |
| memAN | input | 1 | User A memory-select, active low |
| rdB | input | 1 | User B read (1) / write (0) |
| enBN | input | 1 | User B output enable, active low |
| memBN | input | 1 | User B memory-select, active low |
| uaIn | input | 16 | User A bus, inbound |
| uaOut | output | 16 | User A bus, outbound |
| uaOe | output | 1 | User A bus drive enable |
| ubIn | input | 16 | User B bus, inbound |
| ubOut | output | 16 | User B bus, outbound |
| ubOe | output | 1 | User B bus drive enable |
| mdIn | input | 16 | Memory data, inbound |
| mdOut | output | 16 | Memory data, outbound |
| mdOe | output | 1 | Memory data drive enable |
| mcIn | input | 8 | Stored check bits, inbound |
| mcOut | output | 8 | Generated check bits, outbound |
| mcOe | output | 1 | Check bus drive enable |
| ceN | output | 1 | Correctable error flag, active low |
| ueN | output | 1 | Uncorrectable error flag, active low |

## Verification
A wrong decode of the master or the transaction type shows up one cycle after the stimulus. It appears as a bus driven in the wrong direction, as both user buses driven during a transfer, or as memory driven while `memSel` is low. A wrong codec column or syndrome mapping shows on the same cycle as a flipped bit in a corrected word, or as the wrong flag, when one bit of the stored 24 is corrupted. A stale output register shows a cycle later as a value left over from the previous transaction, so the bench compares every output on every cycle.

// File: rtl/bus_router_pkg.sv
package bus_router_pkg;

  // Strobes from control to datapath; one transaction per cycle.
  typedef struct packed {
    logic masterIsB;     // user B owns the transaction
    logic memWrite;      // drive memory data and check buses
    logic memRead;       // return memory word, flags valid
    logic peerToMaster;  // transfer: master pulls peer word
    logic masterToPeer;  // transfer: peer receives master word
    logic masterOe;      // drive the master's bus
    logic peerOe;        // drive the non-master's bus
    logic syndView;      // return syndrome and stored check bits
    logic corrEn;        // return corrected word
  } routeCtl_t;

endpackage

// File: rtl/ecc_codec.sv
module ecc_codec #(
  parameter int DATA_W  = 16,
  parameter int CHECK_W = 8
) (
  input  logic [DATA_W-1:0]  encData,
  output logic [CHECK_W-1:0] encCheck,
  input  logic [DATA_W-1:0]  decData,
  input  logic [CHECK_W-1:0] decCheck,
  output logic [CHECK_W-1:0] syndrome,
  output logic [DATA_W-1:0]  fixedData,
  output logic               singleErr,
  output logic               multiErr
);

  typedef logic [DATA_W-1:0][CHECK_W-1:0] colTable_t;

  // Columns: ascending CHECK_W-bit codes with exactly three ones.
  function automatic colTable_t buildCols();
    colTable_t t = '0;
    int n = 0;
    for (int v = 0; v < (1 << CHECK_W); v++) begin
      logic [CHECK_W-1:0] code = v[CHECK_W-1:0];
      if ($countones(code) == 3 && n < DATA_W) begin
        t[n] = code;
        n++;
      end
    end
    return t;
  endfunction

  localparam colTable_t COLS = buildCols();

  function automatic logic [CHECK_W-1:0] calcCheck(input logic [DATA_W-1:0] d);
    logic [CHECK_W-1:0] c = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (d[i]) c ^= COLS[i];
    end
    return c;
  endfunction

  logic [DATA_W-1:0] colHit;

  assign encCheck = calcCheck(encData);
  assign syndrome = calcCheck(decData) ^ decCheck;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bitFix
    assign colHit[i]    = (syndrome == COLS[i]);
    assign fixedData[i] = decData[i] ^ colHit[i];
  end

  assign singleErr = (|colHit) || ($countones(syndrome) == 1);
  assign multiErr  = (syndrome != '0) && !singleErr;

endmodule

// File: rtl/router_ctrl.sv
module router_ctrl
  import bus_router_pkg::*;
(
  input  logic      memSel,
  input  logic      masterSel,
  input  logic      correctEn,
  input  logic      syndReadN,
  input  logic      rdA,
  input  logic      enAN,
  input  logic      memAN,
  input  logic      rdB,
  input  logic      enBN,
  input  logic      memBN,
  output routeCtl_t ctl
);

  logic mRd, mEnN, mMemN, pEnN, active;

  // Only the master's strobes start anything; peer contributes its enable.
  assign mRd    = masterSel ? rdB   : rdA;
  assign mEnN   = masterSel ? enBN  : enAN;
  assign mMemN  = masterSel ? memBN : memAN;
  assign pEnN   = masterSel ? enAN  : enBN;
  assign active = !mMemN;

  always_comb begin
    ctl              = '0;
    ctl.masterIsB    = masterSel;
    ctl.memWrite     = active &&  memSel && !mRd;
    ctl.memRead      = active &&  memSel &&  mRd;
    ctl.peerToMaster = active && !memSel &&  mRd;
    ctl.masterToPeer = active && !memSel && !mRd;
    ctl.masterOe     = !mEnN && (ctl.memRead || ctl.peerToMaster);
    ctl.peerOe       = !pEnN && (ctl.memRead || ctl.memWrite || ctl.masterToPeer);
    ctl.syndView     = ctl.memRead && !syndReadN;
    ctl.corrEn       = ctl.memRead && correctEn;
  end

endmodule

// File: rtl/router_dpath.sv
module router_dpath
  import bus_router_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CHECK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  routeCtl_t          ctl,
  input  logic [DATA_W-1:0]  uaIn,
  input  logic [DATA_W-1:0]  ubIn,
  input  logic [DATA_W-1:0]  mdIn,
  input  logic [CHECK_W-1:0] mcIn,
  output logic [DATA_W-1:0]  uaOut,
  output logic               uaOe,
  output logic [DATA_W-1:0]  ubOut,
  output logic               ubOe,
  output logic [DATA_W-1:0]  mdOut,
  output logic               mdOe,
  output logic [CHECK_W-1:0] mcOut,
  output logic               mcOe,
  output logic               ceN,
  output logic               ueN
);

  localparam int VIEW_W = 2 * CHECK_W;

  logic [DATA_W-1:0]  masterIn, peerIn, viewWord, readWord, masterWord, peerWord;
  logic [DATA_W-1:0]  fixedData, uaNext, ubNext;
  logic [CHECK_W-1:0] genCheck, syndrome;
  logic               singleErr, multiErr, uaOeNext, ubOeNext;

  assign masterIn = ctl.masterIsB ? ubIn : uaIn;
  assign peerIn   = ctl.masterIsB ? uaIn : ubIn;

  ecc_codec #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) i_codec (
    .encData  (masterIn),
    .encCheck (genCheck),
    .decData  (mdIn),
    .decCheck (mcIn),
    .syndrome (syndrome),
    .fixedData(fixedData),
    .singleErr(singleErr),
    .multiErr (multiErr)
  );

  always_comb begin
    viewWord               = '0;
    viewWord[VIEW_W-1:0]   = {syndrome, mcIn};
  end

  assign readWord   = ctl.syndView ? viewWord : (ctl.corrEn ? fixedData : mdIn);
  assign masterWord = ctl.peerToMaster ? peerIn : readWord;
  assign peerWord   = (ctl.masterToPeer || ctl.memWrite) ? masterIn : readWord;

  assign uaOeNext = ctl.masterIsB ? ctl.peerOe   : ctl.masterOe;
  assign ubOeNext = ctl.masterIsB ? ctl.masterOe : ctl.peerOe;
  assign uaNext   = !uaOeNext ? '0 : (ctl.masterIsB ? peerWord : masterWord);
  assign ubNext   = !ubOeNext ? '0 : (ctl.masterIsB ? masterWord : peerWord);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uaOut <= '0;
      uaOe  <= 1'b0;
      ubOut <= '0;
      ubOe  <= 1'b0;
      mdOut <= '0;
      mdOe  <= 1'b0;
      mcOut <= '0;
      mcOe  <= 1'b0;
      ceN   <= 1'b1;
      ueN   <= 1'b1;
    end else begin
      uaOut <= uaNext;
      uaOe  <= uaOeNext;
      ubOut <= ubNext;
      ubOe  <= ubOeNext;
      mdOut <= ctl.memWrite ? masterIn : '0;
      mdOe  <= ctl.memWrite;
      mcOut <= ctl.memWrite ? genCheck : '0;
      mcOe  <= ctl.memWrite;
      ceN   <= !(ctl.memRead && singleErr);
      ueN   <= !(ctl.memRead && multiErr);
    end
  end

endmodule

// File: rtl/dual_user_bus_router.sv
module dual_user_bus_router
  import bus_router_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CHECK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               memSel,
  input  logic               masterSel,
  input  logic               correctEn,
  input  logic               syndReadN,
  input  logic               rdA,
  input  logic               enAN,
  input  logic               memAN,
  input  logic               rdB,
  input  logic               enBN,
  input  logic               memBN,
  input  logic [DATA_W-1:0]  uaIn,
  output logic [DATA_W-1:0]  uaOut,
  output logic               uaOe,
  input  logic [DATA_W-1:0]  ubIn,
  output logic [DATA_W-1:0]  ubOut,
  output logic               ubOe,
  input  logic [DATA_W-1:0]  mdIn,
  output logic [DATA_W-1:0]  mdOut,
  output logic               mdOe,
  input  logic [CHECK_W-1:0] mcIn,
  output logic [CHECK_W-1:0] mcOut,
  output logic               mcOe,
  output logic               ceN,
  output logic               ueN
);

  routeCtl_t ctl;

  router_ctrl i_ctrl (
    .memSel   (memSel),
    .masterSel(masterSel),
    .correctEn(correctEn),
    .syndReadN(syndReadN),
    .rdA      (rdA),
    .enAN     (enAN),
    .memAN    (memAN),
    .rdB      (rdB),
    .enBN     (enBN),
    .memBN    (memBN),
    .ctl      (ctl)
  );

  router_dpath #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) i_dpath (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .uaIn (uaIn),
    .ubIn (ubIn),
    .mdIn (mdIn),
    .mcIn (mcIn),
    .uaOut(uaOut),
    .uaOe (uaOe),
    .ubOut(ubOut),
    .ubOe (ubOe),
    .mdOut(mdOut),
    .mdOe (mdOe),
    .mcOut(mcOut),
    .mcOe (mcOe),
    .ceN  (ceN),
    .ueN  (ueN)
  );

endmodule

// File: rtl/router_checker.sv
module router_checker (
  input logic clk,
  input logic rstN,
  input logic memSel,
  input logic enAN,
  input logic enBN,
  input logic uaOe,
  input logic ubOe,
  input logic mdOe,
  input logic mcOe,
  input logic ceN,
  input logic ueN
);

  a_r7_mem_idle_in_transfer: assert property (@(posedge clk) disable iff (!rstN)
    !memSel |=> (!mdOe && !mcOe));

  a_r7_single_user_driven: assert property (@(posedge clk) disable iff (!rstN)
    !memSel |=> !(uaOe && ubOe));

  a_r10_flags_idle_off_memory: assert property (@(posedge clk) disable iff (!rstN)
    !memSel |=> (ceN && ueN));

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!ceN && !ueN));

  a_r9_no_enable_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (enAN && enBN) |=> (!uaOe && !ubOe));

  a_r2_check_with_data: assert property (@(posedge clk) disable iff (!rstN)
    mdOe == mcOe);

endmodule

bind dual_user_bus_router router_checker i_chk (.*);

// File: tb/test_dual_user_bus_router.sv
module test_dual_user_bus_router;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int CW = 8;

  typedef struct packed {
    logic memSel, masterSel, correctEn, syndReadN;
    logic rdA, enAN, memAN, rdB, enBN, memBN;
    logic [DW-1:0] uaIn, ubIn, mdIn;
    logic [CW-1:0] mcIn;
  } stim_t;

  typedef struct {
    logic [DW-1:0] ua, ub, md;
    logic [CW-1:0] mc;
    logic uaOe, ubOe, mdOe, mcOe, ceN, ueN;
    string mTag, pTag, fTag, memTag;
    logic  masterIsB;
  } exp_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic memSel, masterSel, correctEn, syndReadN;
  logic rdA, enAN, memAN, rdB, enBN, memBN;
  logic [DW-1:0] uaIn, ubIn, mdIn, uaOut, ubOut, mdOut;
  logic [CW-1:0] mcIn, mcOut;
  logic uaOe, ubOe, mdOe, mcOe, ceN, ueN;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  dual_user_bus_router #(.DATA_W(DW), .CHECK_W(CW)) i_dual_user_bus_router (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Column of data bit i per R2: i-th ascending code with three ones.
  function automatic logic [CW-1:0] col(int i);
    int n = 0;
    for (int v = 0; v < 256; v++) begin
      logic [CW-1:0] c = v[CW-1:0];
      if ($countones(c) == 3) begin
        if (n == i) return c;
        n++;
      end
    end
    return '0;
  endfunction

  function automatic logic [CW-1:0] chk(logic [DW-1:0] d);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < DW; i++) if (d[i]) c ^= col(i);
    return c;
  endfunction

  function automatic exp_t model(stim_t s);
    exp_t e;
    logic mRd, mEnN, active, pEnN, single, multi, mOe, pOe;
    logic [DW-1:0] wM, wP, fixed, readW, mW, pW;
    logic [CW-1:0] syn;
    mRd    = s.masterSel ? s.rdB  : s.rdA;
    mEnN   = s.masterSel ? s.enBN : s.enAN;
    pEnN   = s.masterSel ? s.enAN : s.enBN;
    active = !(s.masterSel ? s.memBN : s.memAN);
    wM     = s.masterSel ? s.ubIn : s.uaIn;
    wP     = s.masterSel ? s.uaIn : s.ubIn;
    syn    = chk(s.mdIn) ^ s.mcIn;
    fixed  = s.mdIn;
    single = ($countones(syn) == 1);
    for (int i = 0; i < DW; i++) if (syn == col(i)) begin fixed[i] = ~fixed[i]; single = 1; end
    multi  = (syn != 0) && !single;
    readW  = !s.syndReadN ? {syn, s.mcIn} : (s.correctEn ? fixed : s.mdIn);
    e.md = '0; e.mc = '0; e.mdOe = 0; e.mcOe = 0; e.ceN = 1; e.ueN = 1;
    mOe = 0; pOe = 0; mW = '0; pW = '0;
    e.mTag = "R8"; e.pTag = "R8"; e.fTag = "R10"; e.memTag = "R8";
    e.masterIsB = s.masterSel;
    if (active && s.memSel && !mRd) begin
      e.md = wM; e.mc = chk(wM); e.mdOe = 1; e.mcOe = 1;
      pOe = !pEnN; pW = wM; e.mTag = "R2"; e.pTag = "R3"; e.memTag = "R2";
    end else if (active && s.memSel && mRd) begin
      mOe = !mEnN; mW = readW; pOe = !pEnN; pW = readW;
      e.ceN = !single; e.ueN = !multi; e.fTag = "R5";
      e.mTag = !s.syndReadN ? "R6" : "R4"; e.pTag = "R3"; e.memTag = "R4";
    end else if (active && !s.memSel && mRd) begin
      mOe = !mEnN; mW = wP; e.mTag = "R7"; e.pTag = "R7"; e.memTag = "R7";
    end else if (active && !s.memSel) begin
      pOe = !pEnN; pW = wM; e.mTag = "R7"; e.pTag = "R3"; e.memTag = "R7";
    end else if (!s.memSel) e.memTag = "R7";
    e.uaOe = s.masterSel ? pOe : mOe;
    e.ubOe = s.masterSel ? mOe : pOe;
    e.ua = e.uaOe ? (s.masterSel ? pW : mW) : '0;
    e.ub = e.ubOe ? (s.masterSel ? mW : pW) : '0;
    return e;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(exp_t e);
    check(e.masterIsB ? e.pTag : e.mTag, "uaOut", uaOut, e.ua);
    check(e.masterIsB ? e.mTag : e.pTag, "ubOut", ubOut, e.ub);
    check("R9", "uaOe", uaOe, e.uaOe);
    check("R9", "ubOe", ubOe, e.ubOe);
    check(e.memTag, "mdOut/mdOe", {mdOe, mdOut}, {e.mdOe, e.md});
    check(e.memTag, "mcOut/mcOe", {mcOe, mcOut}, {e.mcOe, e.mc});
    check(e.fTag, "flags", {ceN, ueN}, {e.ceN, e.ueN});
  endtask

  task automatic apply(stim_t s);
    memSel = s.memSel; masterSel = s.masterSel; correctEn = s.correctEn;
    syndReadN = s.syndReadN; rdA = s.rdA; enAN = s.enAN; memAN = s.memAN;
    rdB = s.rdB; enBN = s.enBN; memBN = s.memBN;
    uaIn = s.uaIn; ubIn = s.ubIn; mdIn = s.mdIn; mcIn = s.mcIn;
  endtask

  exp_t expNow;

  task automatic step(stim_t s);
    @(negedge clk);
    compareAll(expNow);
    apply(s);
    expNow = model(s);
  endtask

  function automatic stim_t idle();
    stim_t s = '0;
    s.memSel = 1; s.syndReadN = 1; s.enAN = 1; s.memAN = 1; s.enBN = 1; s.memBN = 1;
    return s;
  endfunction

  // Memory word with a given number of bit flips at chosen positions (0..23).
  function automatic stim_t withMem(stim_t s, logic [DW-1:0] d, int p0, int p1);
    logic [DW+CW-1:0] w = {chk(d), d};
    if (p0 >= 0) w[p0] = ~w[p0];
    if (p1 >= 0) w[p1] = ~w[p1];
    s.mdIn = w[DW-1:0]; s.mcIn = w[DW+CW-1:DW];
    return s;
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    stim_t s;
    void'($urandom(32'h1BAD5EED));
    // R1: active write held during reset must not reach outputs
    s = idle(); s.memAN = 0; s.rdA = 0; s.uaIn = 16'hBEEF; s.enBN = 0;
    apply(s);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset outs", {uaOe, ubOe, mdOe, mcOe, ceN, ueN}, 6'b000011);
    check("R1", "reset data", {uaOut, ubOut, mdOut}, '0);
    rstN = 1;
    expNow = model(s);
    // R2/R10: write from A, B listening, correct and readback asserted
    s = idle(); s.memAN = 0; s.rdA = 0; s.enBN = 0; s.uaIn = 16'h1234;
    s.correctEn = 1; s.syndReadN = 0; s = withMem(s, 16'h0F0F, 3, 9);
    step(s);
    // R4/R5: single data error, corrected then raw
    s = idle(); s.memAN = 0; s.rdA = 1; s.enAN = 0; s.enBN = 0; s.correctEn = 1;
    s = withMem(s, 16'hA5C3, 6, -1);
    step(s);
    s.correctEn = 0; step(s);
    // R5: check-bit error corrects nothing
    s.correctEn = 1; s = withMem(s, 16'h7E81, 20, -1); step(s);
    // R5: double error
    s = withMem(s, 16'h7E81, 2, 17); step(s);
    // R6: readback
    s.syndReadN = 0; s = withMem(s, 16'h0001, 0, -1); step(s);
    // R8: A strobes active but B is master and idle
    s = idle(); s.masterSel = 1; s.memAN = 0; s.rdA = 0; s.enAN = 0; s.uaIn = 16'hCAFE;
    step(s);
    // R7: transfers both ways, B master
    s = idle(); s.memSel = 0; s.masterSel = 1; s.memBN = 0; s.rdB = 0; s.enAN = 0;
    s.ubIn = 16'h55AA; s.uaIn = 16'h1111; step(s);
    s.rdB = 1; s.enBN = 0; s.enAN = 1; step(s);
    // R9: enables high during a read
    s = idle(); s.memAN = 0; s.rdA = 1; s = withMem(s, 16'h3C3C, -1, -1); step(s);
    // Random mix
    for (int n = 0; n < 600; n++) begin
      int k = $urandom_range(0, 2);
      int p0 = $urandom_range(0, DW + CW - 1);
      int p1 = (p0 + $urandom_range(1, DW + CW - 1)) % (DW + CW);
      logic [31:0] r = $urandom;
      s.memSel = ($urandom_range(0, 3) != 0);
      s.masterSel = r[0]; s.correctEn = r[1]; s.syndReadN = ($urandom_range(0, 3) != 0);
      s.rdA = r[2]; s.enAN = r[3]; s.memAN = r[4]; s.rdB = r[5]; s.enBN = r[6]; s.memBN = r[7];
      s.uaIn = $urandom; s.ubIn = $urandom;
      s = withMem(s, 16'($urandom), (k > 0) ? p0 : -1, (k > 1) ? p1 : -1);
      step(s);
    end
    step(idle());
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule